// File: doc/BRIEF.md
# PCM Highway Time Slot Assigner

This block moves the voice samples of four channels between parallel sample ports and two time-division multiplexed serial PCM highways (A and B). The block runs on the highway bit clock. A frame-sync pulse marks the start of every 125 µs frame, and all bit and byte slot positions are counted from it. Each channel has its own enable, transmit slot, receive slot, highway choice and sample width. Companded samples take one byte slot. Linear samples take two adjacent byte slots, high byte first.

On the transmit side, the sample each channel presents is captured at the frame-sync edge. It is then shifted out most significant bit first in that channel's slot(s). The per-highway output enable is the tri-state control for the data pad. The active-low slot strobe follows that enable, so it can be wired as an open-drain signal. Two global settings change the timing. A clock-slot offset of 0 to 7 bit periods delays every slot boundary. A launch-edge select chooses whether transmit data changes on the rising or the falling clock edge. On the receive side, bits are sampled on the falling edge. A channel's sample is presented, with a one-period valid pulse, once its last bit has arrived.

Top module: `pcm_slot_mapper`

## Requirements
- R1: After reset and until the first frame sync, `dxOe` is 0 and `tscN` is 1 on both highways, and `rxValid` is 0 for all channels.
- R2: The rising edge on which `fs` is sampled high starts a frame. With `clkSlot` = 0, the bit period that follows that edge is bit 0 of slot 0, and bit j (0 = MSB) of slot s occupies period 8*s + j.
- R3: A companded channel (`linMode`=0) sends `txSample[7:0]`, as captured at the frame-sync edge, in its transmit slot on its highway, MSB first.
- R4: A linear channel (`linMode`=1) sends the captured `txSample[15:0]` over slots `txSlot` and `txSlot`+1: bits 15..8 in the first slot, then bits 7..0, MSB first.
- R5: `dxOe` of a highway is 1 only during slots that an enabled channel on that highway transmits in. At all other times it is 0, including for disabled channels. `tscN` of a highway is 0 exactly when its `dxOe` is 1.
- R6: `hwySel` bit c selects the highway for channel c, for both directions: 0 = A (index 0), 1 = B (index 1). The other highway is not driven.
- R7: When several enabled channels transmit in the same slot on the same highway, the lowest-numbered channel's data is sent.
- R8: `clkSlot` (0 to 7) delays all slot boundaries by that many bit periods: bit j of slot s occupies period `clkSlot` + 8*s + j.
- R9: With `txOnFall`=0, transmit data and enables change just after the rising edge that starts each period. With `txOnFall`=1, they are launched at the falling edge in the middle of the period and are held until the next falling edge.
- R10: Received bits are sampled on the falling edge of their period, MSB first. For a companded channel, `rxSample` becomes {8'h00, byte} at the falling edge of the slot's last bit, and `rxValid` is high for that one period only.
- R11: A linear receive channel collects its slot `rxSlot` (bits 15..8) and slot `rxSlot`+1 (bits 7..0) and presents all 16 bits, with `rxValid`, only after the last bit of the second slot.
- R12: All 128 byte slots (0..127) of a 1024-bit frame can be used, including slot 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM highway bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync, sampled on rising edge |
| chEn | input | NUM_CH | Per-channel enable |
| hwySel | input | NUM_CH | Per-channel highway (0 = A, 1 = B) |
| linMode | input | NUM_CH | Per-channel 16-bit linear mode |
| txSlot | input | NUM_CH*SLOT_W | Per-channel transmit slot, channel c at bits [c*SLOT_W +: SLOT_W] |
| rxSlot | input | NUM_CH*SLOT_W | Per-channel receive slot, same packing |
| clkSlot | input | OFF_W | Clock-slot offset in bit periods |
| txOnFall | input | 1 | Launch transmit data on falling edge |
| txSample | input | NUM_CH*16 | Transmit samples, channel c at [c*16 +: 16] |
| dr | input | 2 | Receive serial data, index 0 = A, 1 = B |
| dx | output | 2 | Transmit serial data per highway |
| dxOe | output | 2 | Transmit pad enable per highway |
| tscN | output | 2 | Active-low slot strobe per highway |
| rxSample | output | NUM_CH*16 | Received samples, channel c at [c*16 +: 16] |
| rxValid | output | NUM_CH | One-period received-sample strobe |

## Verification
The bench targets the slot edges. It samples one period before and one period after each active slot. A design with an off-by-one in the slot counter, or in the clock-slot offset, shows a live enable or a shifted byte there. It programs two channels into the same slot to catch a priority encoder that favours the higher channel. It also uses slot 127 in linear-free mode to catch a counter or comparison that wraps early. In falling-edge mode it samples both before and after the mid-period edge, which exposes launch timing that ignores the mode. On receive, it checks that a linear sample appears only after sixteen bits, and that the valid strobe drops after one period.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned SLOT_IDX_W = 8;   // supports up to 256 slots
  localparam int unsigned SAMPLE_W   = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_HWY    = 2;

  typedef struct packed {
    logic                  frameStart;
    logic                  slotValid;
    logic [SLOT_IDX_W-1:0] slot;
    logic [2:0]            bitIdx;
  } slot_strobe_t;
endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 128,
  parameter int unsigned OFF_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fs,
  input  logic [OFF_W-1:0] clkSlot,
  output slot_strobe_t     strb
);
  localparam int unsigned FRAME_BITS = NUM_SLOTS * BYTE_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + (1 << OFF_W)) + 1;
  localparam logic [CNT_W-1:0] CNT_IDLE = '1;

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  bitCnt <= CNT_IDLE;
    else if (fs)                bitCnt <= '0;
    else if (bitCnt != CNT_IDLE) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    pos             = bitCnt - CNT_W'(clkSlot);
    strb.frameStart = fs;
    strb.slotValid  = (bitCnt != CNT_IDLE) && (bitCnt >= CNT_W'(clkSlot)) &&
                      (pos < CNT_W'(FRAME_BITS));
    strb.slot       = SLOT_IDX_W'(pos >> 3);
    strb.bitIdx     = pos[2:0];
  end

  AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    (fs && clkSlot == '0) |=> (strb.slotValid && strb.slot == '0 && strb.bitIdx == 3'd0)); // R2
endmodule

// File: rtl/pcm_slot_dp.sv
module pcm_slot_dp
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_SLOTS = 128,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  slot_strobe_t                 strb,
  input  logic [NUM_CH-1:0]            chEn,
  input  logic [NUM_CH-1:0]            hwySel,
  input  logic [NUM_CH-1:0]            linMode,
  input  logic [NUM_CH*SLOT_W-1:0]     txSlot,
  input  logic [NUM_CH*SLOT_W-1:0]     rxSlot,
  input  logic                         txOnFall,
  input  logic [NUM_CH*SAMPLE_W-1:0]   txSample,
  input  logic [NUM_HWY-1:0]           dr,
  output logic [NUM_HWY-1:0]           dx,
  output logic [NUM_HWY-1:0]           dxOe,
  output logic [NUM_HWY-1:0]           tscN,
  output logic [NUM_CH*SAMPLE_W-1:0]   rxSample,
  output logic [NUM_CH-1:0]            rxValid
);
  localparam int unsigned CMP_W = SLOT_IDX_W + 1;

  logic [NUM_CH-1:0] txHit, txBit;
  logic [NUM_HWY-1:0] bitNow, oeNow, fallBit, fallOe;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] txHold, rxShift;
    logic [CMP_W-1:0]    curSlot, txFirst, rxFirst;
    logic                txHi, rxHit, rxLast;

    assign curSlot = CMP_W'(strb.slot);
    assign txFirst = CMP_W'(txSlot[c*SLOT_W +: SLOT_W]);
    assign rxFirst = CMP_W'(rxSlot[c*SLOT_W +: SLOT_W]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                txHold <= '0;
      else if (strb.frameStart) txHold <= txSample[c*SAMPLE_W +: SAMPLE_W];
    end

    assign txHi     = linMode[c] && (curSlot == txFirst);
    assign txHit[c] = chEn[c] && strb.slotValid &&
                      ((curSlot == txFirst) || (linMode[c] && curSlot == txFirst + 1'b1));
    assign txBit[c] = txHold[{txHi, ~strb.bitIdx}];

    assign rxHit  = chEn[c] && strb.slotValid &&
                    ((curSlot == rxFirst) || (linMode[c] && curSlot == rxFirst + 1'b1));
    assign rxLast = rxHit && (strb.bitIdx == 3'd7) &&
                    (curSlot == (linMode[c] ? rxFirst + 1'b1 : rxFirst));

    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) begin
        rxShift    <= '0;
        rxValid[c] <= 1'b0;
        rxSample[c*SAMPLE_W +: SAMPLE_W] <= '0;
      end else begin
        rxValid[c] <= rxLast;
        if (rxHit) rxShift <= {rxShift[SAMPLE_W-2:0], dr[hwySel[c]]};
        if (rxLast)
          rxSample[c*SAMPLE_W +: SAMPLE_W] <= linMode[c] ?
            {rxShift[SAMPLE_W-2:0], dr[hwySel[c]]} :
            {{BYTE_W{1'b0}}, rxShift[BYTE_W-2:0], dr[hwySel[c]]};
      end
    end

    AST_RX_ONE_PERIOD: assert property (@(negedge clk) disable iff (!rstN)
      rxValid[c] |=> !rxValid[c]); // R10
  end

  for (genvar h = 0; h < NUM_HWY; h++) begin : g_hwy
    logic [NUM_CH-1:0] grant;
    always_comb begin
      grant = '0;
      for (int c = 0; c < NUM_CH; c++)
        if (txHit[c] && (hwySel[c] == h[0]) && (grant == '0)) grant[c] = 1'b1;
      oeNow[h]  = |grant;
      bitNow[h] = |(grant & txBit);
    end

    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) begin
        fallBit[h] <= 1'b0;
        fallOe[h]  <= 1'b0;
      end else begin
        fallBit[h] <= bitNow[h];
        fallOe[h]  <= oeNow[h];
      end
    end

    assign dx[h]   = txOnFall ? fallBit[h] : bitNow[h];
    assign dxOe[h] = txOnFall ? fallOe[h]  : oeNow[h];
    assign tscN[h] = ~dxOe[h];

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
      (!txOnFall && !strb.slotValid) |-> (dxOe[h] == 1'b0 && tscN[h] == 1'b1)); // R5
    AST_LOW_CHANNEL_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (!txOnFall && txHit[0] && hwySel[0] == h[0]) |-> (dxOe[h] && dx[h] == txBit[0])); // R7
  end
endmodule

// File: rtl/pcm_slot_mapper.sv
module pcm_slot_mapper
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_SLOTS = 128,
  parameter int unsigned OFF_W     = 3,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fs,
  input  logic [NUM_CH-1:0]          chEn,
  input  logic [NUM_CH-1:0]          hwySel,
  input  logic [NUM_CH-1:0]          linMode,
  input  logic [NUM_CH*SLOT_W-1:0]   txSlot,
  input  logic [NUM_CH*SLOT_W-1:0]   rxSlot,
  input  logic [OFF_W-1:0]           clkSlot,
  input  logic                       txOnFall,
  input  logic [NUM_CH*16-1:0]       txSample,
  input  logic [1:0]                 dr,
  output logic [1:0]                 dx,
  output logic [1:0]                 dxOe,
  output logic [1:0]                 tscN,
  output logic [NUM_CH*16-1:0]       rxSample,
  output logic [NUM_CH-1:0]          rxValid
);
  slot_strobe_t strb;

  pcm_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fs(fs), .clkSlot(clkSlot), .strb(strb)
  );

  pcm_slot_dp #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chEn(chEn), .hwySel(hwySel),
    .linMode(linMode), .txSlot(txSlot), .rxSlot(rxSlot), .txOnFall(txOnFall),
    .txSample(txSample), .dr(dr), .dx(dx), .dxOe(dxOe), .tscN(tscN),
    .rxSample(rxSample), .rxValid(rxValid)
  );
endmodule

// File: tb/pcm_slot_mapper_tb.sv
`timescale 1ns/1ps
module pcm_slot_mapper_tb;
  localparam int NCH = 4;
  localparam int SW  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fs = 1'b0;
  logic [NCH-1:0] chEn = '0, hwySel = '0, linMode = '0;
  logic [NCH*SW-1:0] txSlot = '0, rxSlot = '0;
  logic [2:0] clkSlot = '0;
  logic txOnFall = 1'b0;
  logic [NCH*16-1:0] txSample = '0;
  logic [1:0] dr = '0;
  logic [1:0] dx, dxOe, tscN;
  logic [NCH*16-1:0] rxSample;
  logic [NCH-1:0] rxValid;

  int checks = 0;
  int errors = 0;
  realtime t0 = 0.0;

  always #2.5 clk = ~clk;

  pcm_slot_mapper u_dut (
    .clk(clk), .rstN(rstN), .fs(fs), .chEn(chEn), .hwySel(hwySel),
    .linMode(linMode), .txSlot(txSlot), .rxSlot(rxSlot), .clkSlot(clkSlot),
    .txOnFall(txOnFall), .txSample(txSample), .dr(dr), .dx(dx), .dxOe(dxOe),
    .tscN(tscN), .rxSample(rxSample), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearCfg();
    chEn = '0; hwySel = '0; linMode = '0; txSlot = '0; rxSlot = '0;
    clkSlot = '0; txOnFall = 1'b0; txSample = '0; dr = '0;
  endtask

  task automatic startFrame();
    @(negedge clk); fs = 1'b1;
    @(posedge clk); t0 = $realtime;
    @(negedge clk); fs = 1'b0;
  endtask

  // go to period k at offset d ns after its opening rising edge
  task automatic goPer(input int k, input real d);
    #(t0 + 5.0 * k + d - $realtime);
  endtask

  task automatic grabTx(input int h, input int k0, input int n,
                        output logic [15:0] v, output bit oeAll, output bit tscOk);
    v = '0; oeAll = 1'b1; tscOk = 1'b1;
    for (int i = 0; i < n; i++) begin
      goPer(k0 + i, 4.0);
      v = {v[14:0], dx[h]};
      oeAll &= dxOe[h];
      tscOk &= (tscN[h] == 1'b0);
    end
  endtask

  task automatic driveRx(input int h, input int k0, input int n, input logic [15:0] val);
    for (int i = 0; i < n; i++) begin
      goPer(k0 + i, 1.0);
      dr[h] = val[n-1-i];
    end
  endtask

  task automatic testReset();
    check(dxOe == 2'b00, "R1 dxOe after reset", dxOe, 0);
    check(tscN == 2'b11, "R1 tscN after reset", tscN, 3);
    check(rxValid == '0, "R1 rxValid after reset", rxValid, 0);
  endtask

  task automatic testCompanded();
    logic [15:0] v; bit oe, ts;
    clearCfg();
    chEn[0] = 1'b1; txSlot[0*SW +: SW] = 7'd2; txSample[0*16 +: 16] = 16'h77A5;
    startFrame();
    goPer(15, 4.0);
    check(dxOe[0] == 1'b0 && tscN[0] == 1'b1, "R5 before slot idle", dxOe[0], 0);
    grabTx(0, 16, 8, v, oe, ts);
    check(v[7:0] == 8'hA5, "R2 R3 companded byte", v[7:0], 8'hA5);
    check(oe && ts, "R5 enable and strobe in slot", {oe, ts}, 3);
    goPer(24, 4.0);
    check(dxOe[0] == 1'b0 && tscN[0] == 1'b1, "R5 after slot idle", dxOe[0], 0);
  endtask

  task automatic testLinearHwyB();
    logic [15:0] v; bit oe, ts; bit otherIdle;
    clearCfg();
    chEn[1] = 1'b1; hwySel[1] = 1'b1; linMode[1] = 1'b1;
    txSlot[1*SW +: SW] = 7'd5; txSample[1*16 +: 16] = 16'h1234;
    startFrame();
    otherIdle = 1'b1;
    v = '0; oe = 1'b1; ts = 1'b1;
    for (int i = 0; i < 16; i++) begin
      goPer(40 + i, 4.0);
      v = {v[14:0], dx[1]};
      oe &= dxOe[1]; ts &= (tscN[1] == 1'b0);
      otherIdle &= (dxOe[0] == 1'b0 && tscN[0] == 1'b1);
    end
    check(v == 16'h1234, "R4 linear two slots", v, 16'h1234);
    check(oe && ts, "R4 R5 linear enable spans both slots", {oe, ts}, 3);
    check(otherIdle, "R6 highway A not driven", otherIdle, 1);
  endtask

  task automatic testPriority();
    logic [15:0] v; bit oe, ts;
    clearCfg();
    chEn = 4'b1110;
    txSlot[2*SW +: SW] = 7'd3; txSample[2*16 +: 16] = 16'h003C;
    txSlot[3*SW +: SW] = 7'd3; txSample[3*16 +: 16] = 16'h00C3;
    txSlot[0*SW +: SW] = 7'd1; txSample[0*16 +: 16] = 16'h00FF;  // disabled
    startFrame();
    grabTx(0, 8, 8, v, oe, ts);
    check(!oe && ts == 1'b0, "R5 disabled channel not driven", oe, 0);
    grabTx(0, 24, 8, v, oe, ts);
    check(v[7:0] == 8'h3C && oe, "R7 lower channel wins", v[7:0], 8'h3C);
  endtask

  task automatic testOffset();
    logic [15:0] v; bit oe, ts;
    clearCfg();
    chEn[0] = 1'b1; clkSlot = 3'd3; txSample[0*16 +: 16] = 16'h0096;
    startFrame();
    goPer(2, 4.0);
    check(dxOe[0] == 1'b0, "R8 offset delays slot 0", dxOe[0], 0);
    grabTx(0, 3, 8, v, oe, ts);
    check(v[7:0] == 8'h96 && oe && ts, "R8 offset byte", v[7:0], 8'h96);
  endtask

  task automatic testFallEdge();
    logic [15:0] v; bit oe, ts;
    clearCfg();
    chEn[0] = 1'b1; txOnFall = 1'b1; txSlot[0*SW +: SW] = 7'd1;
    txSample[0*16 +: 16] = 16'h00B1;
    startFrame();
    goPer(8, 1.0);
    check(dxOe[0] == 1'b0 && tscN[0] == 1'b1, "R9 not launched before falling edge", dxOe[0], 0);
    grabTx(0, 8, 8, v, oe, ts);
    check(v[7:0] == 8'hB1 && oe && ts, "R9 falling-edge byte", v[7:0], 8'hB1);
    goPer(16, 1.0);
    check(dxOe[0] == 1'b1 && dx[0] == 1'b1, "R9 last bit held past rising edge", {dxOe[0], dx[0]}, 3);
    goPer(16, 4.0);
    check(dxOe[0] == 1'b0, "R9 released at falling edge", dxOe[0], 0);
  endtask

  task automatic testRx();
    clearCfg();
    chEn[0] = 1'b1; rxSlot[0*SW +: SW] = 7'd4;
    startFrame();
    driveRx(0, 32, 7, 16'h006B >> 1);
    goPer(38, 4.0);
    check(rxValid[0] == 1'b0, "R10 no valid before last bit", rxValid[0], 0);
    driveRx(0, 39, 1, 16'h0001);
    goPer(39, 4.0);
    check(rxValid[0] == 1'b1 && rxSample[0*16 +: 16] == 16'h006B,
          "R10 companded receive", rxSample[0*16 +: 16], 16'h006B);
    goPer(40, 4.0);
    check(rxValid[0] == 1'b0, "R10 valid lasts one period", rxValid[0], 0);

    clearCfg();
    chEn[1] = 1'b1; hwySel[1] = 1'b1; linMode[1] = 1'b1; rxSlot[1*SW +: SW] = 7'd10;
    startFrame();
    driveRx(1, 80, 8, 16'h00BE);
    goPer(87, 4.0);
    check(rxValid[1] == 1'b0, "R11 no valid after first byte", rxValid[1], 0);
    driveRx(1, 88, 8, 16'h00EF);
    goPer(95, 4.0);
    check(rxValid[1] == 1'b1 && rxSample[1*16 +: 16] == 16'hBEEF,
          "R11 R6 linear receive on B", rxSample[1*16 +: 16], 16'hBEEF);
  endtask

  task automatic testLastSlot();
    logic [15:0] v; bit oe, ts;
    clearCfg();
    chEn[3] = 1'b1; txSlot[3*SW +: SW] = 7'd127; txSample[3*16 +: 16] = 16'h0081;
    startFrame();
    goPer(1015, 4.0);
    check(dxOe[0] == 1'b0, "R12 idle before slot 127", dxOe[0], 0);
    grabTx(0, 1016, 8, v, oe, ts);
    check(v[7:0] == 8'h81 && oe && ts, "R12 slot 127 byte", v[7:0], 8'h81);
    goPer(1024, 4.0);
    check(dxOe[0] == 1'b0, "R12 released after slot 127", dxOe[0], 0);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testCompanded();
    testLinearHwyB();
    testPriority();
    testOffset();
    testFallEdge();
    testRx();
    testLastSlot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule